// File: doc/BRIEF.md
# Planar Pixel Color Decoder

This block sits at the end of a planar display pipeline. Each pixel arrives as up to six plane bits, one bit from each bitplane, and the block turns them into a 12-bit RGB value. It holds a palette of 32 colour registers, which are loaded through a simple write port. Per pixel it selects one of four decode modes. The mode depends on the active plane count, a high-resolution flag, a hold-and-modify request, a dual-playfield request and a window-active input.

The four decode modes are named after the enumeration in the RTL:
- **DM_BORDER**: the pixel lies outside the display window.
- **DM_PALETTE**: plain indexed colour.
- **DM_HALFBRITE**: the sixth plane dims the indexed colour to half brightness.
- **DM_HAM**: the upper two plane bits choose between a direct palette pick and changing one colour channel of the previous pixel.

The mode is chosen again for every pixel. It is a pure function of the current inputs, so no transition carries history. The only history is the hold register used by DM_HAM. It is reloaded from colour register 0 when a line begins, and it is overwritten by every hold-and-modify pixel.

Plane bits are combined into a palette index, with plane 1 as index bit 0. Planes above the active count are ignored. The result is registered and appears one clock after the pixel strobe, flagged by a valid output.

Top module: `planar_color_decoder`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[11:0]` into the register at `wr_addr`. Red is in bits 11:8, green in 7:4 and blue in 3:0. `wr_data[15:12]` is discarded. A pixel that reads the register afterwards shows the stored value.
- R2: `plane_cnt` sets the number of active planes. Bit i of `pix_bits` is index bit i, so plane 1 maps to bit 0. Bits at or above the active count are treated as zero. A count of 0 gives index 0, and a count of 7 acts as 6. With 1 to 5 planes, the output is the register selected by the index.
- R3: When `hires` is 1, the active count is limited to 4. Index bits 4 and 5 are then zero, and neither half-brite nor hold-and-modify can take effect.
- R4: With 6 active planes, `ham_en` low and `dual_pf` low, the mode is half-brite. Bits 4:0 select a register. If bit 5 is 1, each of the three 4-bit components is shifted right by one.
- R5: In hold-and-modify mode (6 active planes, `ham_en` high, `dual_pf` low), pixel code bits 5:4 = 00 output register `pix_bits[3:0]`.
- R6: In hold-and-modify mode, code 01 replaces blue with `pix_bits[3:0]`, 10 replaces red and 11 replaces green. The other two components come from the previous colour.
- R7: A `line_start` pulse loads the previous colour from register 0. A hold-and-modify pixel presented in the same cycle as `line_start` uses register 0 as its previous colour.
- R8: Every valid hold-and-modify pixel inside the window, including code 00, becomes the previous colour. Pixels outside the window leave the previous colour unchanged.
- R9: When `win_active` is 0, the output is register 0 whatever the other inputs are.
- R10: If `ham_en` and `dual_pf` are both high, hold-and-modify is ignored and indexing uses bits 4:0 with no halving. `mode_err` goes to 1 on the next clock and stays at 1 until reset.
- R11: `rgb_valid` is `pix_valid` delayed by one clock. When no pixel was presented in the previous cycle, `rgb_out` keeps its value.
- R12: Reset clears all palette registers, `rgb_out`, `rgb_valid` and `mode_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Palette write strobe |
| wr_addr | input | 5 | Palette register number |
| wr_data | input | 16 | Write data; bits 11:0 are stored |
| line_start | input | 1 | First-pixel-of-line strobe |
| pix_valid | input | 1 | Pixel strobe |
| pix_bits | input | 6 | Plane bits, plane 1 in bit 0 |
| plane_cnt | input | 3 | Active plane count |
| hires | input | 1 | High-resolution flag |
| ham_en | input | 1 | Hold-and-modify request |
| dual_pf | input | 1 | Dual-playfield request |
| win_active | input | 1 | Pixel lies inside the display window |
| rgb_out | output | 12 | Registered pixel colour |
| rgb_valid | output | 1 | `rgb_out` holds a new pixel |
| mode_err | output | 1 | Sticky conflicting-mode flag |

## Verification
The only hidden state that can go wrong without being seen at once is the hold-and-modify previous colour. A corrupt value is visible one clock later, in the two unchanged channels of the next modify pixel. A hold register that missed a line-start reload, or that was updated by a border pixel, shows up at the first modify pixel after the event. For this reason the stimulus puts a modify code immediately after each such event. A wrong mode choice or a wrong index mask shows in the very next output, because every other path is stateless apart from the single output register.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    typedef enum logic [1:0] {
        DM_BORDER    = 2'd0,
        DM_PALETTE   = 2'd1,
        DM_HALFBRITE = 2'd2,
        DM_HAM       = 2'd3
    } dmode_e;
endpackage

// File: rtl/pcd_palette.sv
module pcd_palette #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 12,
    parameter int BUS_W    = 16,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_color,
    output logic [DATA_W-1:0] bg_color
);
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              unused_hi;

    assign unused_hi = ^wr_data[BUS_W-1:DATA_W];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && wr_addr == AW'(g)) begin
                regs[g] <= wr_data[DATA_W-1:0];
            end
        end
    end

    assign rd_color = regs[rd_idx];
    assign bg_color = regs[0];
endmodule

// File: rtl/pcd_mode_sel.sv
module pcd_mode_sel
    import pcd_pkg::*;
#(
    parameter int MAX_PLANES   = 6,
    parameter int HIRES_PLANES = 4,
    parameter int CNT_W        = $clog2(MAX_PLANES + 1),
    parameter int IDX_W        = MAX_PLANES - 1,
    parameter int COMP_W       = MAX_PLANES - 2
) (
    input  logic [MAX_PLANES-1:0] pix_bits,
    input  logic [CNT_W-1:0]      plane_cnt,
    input  logic                  hires,
    input  logic                  ham_req,
    input  logic                  dual_req,
    input  logic                  win_active,
    output dmode_e                mode,
    output logic [IDX_W-1:0]      pal_idx,
    output logic [1:0]            ham_ctl,
    output logic [COMP_W-1:0]     ham_val,
    output logic                  ehb_bit,
    output logic                  conflict
);
    logic [CNT_W-1:0]      limit;
    logic [CNT_W-1:0]      eff;
    logic [MAX_PLANES-1:0] masked;
    logic                  full_set;

    assign limit    = hires ? CNT_W'(HIRES_PLANES) : CNT_W'(MAX_PLANES);
    assign eff      = (plane_cnt > limit) ? limit : plane_cnt;
    assign full_set = (eff == CNT_W'(MAX_PLANES));
    assign conflict = ham_req & dual_req;

    for (genvar i = 0; i < MAX_PLANES; i++) begin : g_mask
        assign masked[i] = pix_bits[i] & (CNT_W'(i) < eff);
    end

    always_comb begin
        if (!win_active) begin
            mode = DM_BORDER;
        end else if (full_set && ham_req && !dual_req) begin
            mode = DM_HAM;
        end else if (full_set && !ham_req && !dual_req) begin
            mode = DM_HALFBRITE;
        end else begin
            mode = DM_PALETTE;
        end
    end

    always_comb begin
        unique case (mode)
            DM_BORDER:    pal_idx = '0;
            DM_HAM:       pal_idx = IDX_W'(masked[COMP_W-1:0]);
            DM_HALFBRITE: pal_idx = masked[IDX_W-1:0];
            DM_PALETTE:   pal_idx = masked[IDX_W-1:0];
            default:      pal_idx = '0;
        endcase
    end

    assign ham_ctl = masked[MAX_PLANES-1 -: 2];
    assign ham_val = masked[COMP_W-1:0];
    assign ehb_bit = masked[MAX_PLANES-1];
endmodule

// File: rtl/pcd_ham_hold.sv
module pcd_ham_hold #(
    parameter int COMP_W = 4,
    parameter int RGB_W  = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              upd,
    input  logic [RGB_W-1:0]  bg_color,
    input  logic [RGB_W-1:0]  direct_color,
    input  logic [1:0]        ham_ctl,
    input  logic [COMP_W-1:0] ham_val,
    output logic [RGB_W-1:0]  ham_color
);
    localparam int R_LO = 2 * COMP_W;
    localparam int G_LO = COMP_W;

    logic [RGB_W-1:0] hold_q;
    logic [RGB_W-1:0] prev;

    assign prev = line_start ? bg_color : hold_q;

    always_comb begin
        unique case (ham_ctl)
            2'b00: ham_color = direct_color;
            2'b01: ham_color = {prev[RGB_W-1:G_LO], ham_val};
            2'b10: ham_color = {ham_val, prev[R_LO-1:0]};
            2'b11: ham_color = {prev[RGB_W-1:R_LO], ham_val, prev[G_LO-1:0]};
            default: ham_color = direct_color;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (upd) begin
            hold_q <= ham_color;
        end else if (line_start) begin
            hold_q <= bg_color;
        end
    end

    // R7: a line start without a modify pixel reloads the background colour
    a_r7_line_reload: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && !upd |=> hold_q == $past(bg_color));

    // R6: a blue-modify pixel keeps red and green of the held colour
    a_r6_blue_keeps_rg: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !line_start && ham_ctl == 2'b01 |=>
        hold_q[RGB_W-1:G_LO] == $past(hold_q[RGB_W-1:G_LO]));
endmodule

// File: rtl/planar_color_decoder.sv
module planar_color_decoder
    import pcd_pkg::*;
#(
    parameter int NUM_REGS     = 32,
    parameter int MAX_PLANES   = 6,
    parameter int HIRES_PLANES = 4,
    parameter int COMP_W       = 4,
    parameter int BUS_W        = 16,
    parameter int AW           = $clog2(NUM_REGS),
    parameter int CNT_W        = $clog2(MAX_PLANES + 1),
    parameter int RGB_W        = 3 * COMP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [BUS_W-1:0]      wr_data,
    input  logic                  line_start,
    input  logic                  pix_valid,
    input  logic [MAX_PLANES-1:0] pix_bits,
    input  logic [CNT_W-1:0]      plane_cnt,
    input  logic                  hires,
    input  logic                  ham_en,
    input  logic                  dual_pf,
    input  logic                  win_active,
    output logic [RGB_W-1:0]      rgb_out,
    output logic                  rgb_valid,
    output logic                  mode_err
);
    localparam int IDX_W = MAX_PLANES - 1;

    dmode_e              mode;
    logic [IDX_W-1:0]    pal_idx;
    logic [1:0]          ham_ctl;
    logic [COMP_W-1:0]   ham_val;
    logic                ehb_bit;
    logic                conflict;
    logic [RGB_W-1:0]    rd_color;
    logic [RGB_W-1:0]    bg_color;
    logic [RGB_W-1:0]    ham_color;
    logic [RGB_W-1:0]    halved;
    logic [RGB_W-1:0]    next_rgb;
    logic                ham_upd;

    pcd_palette #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (RGB_W),
        .BUS_W    (BUS_W),
        .AW       (AW)
    ) u_palette (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_idx   (AW'(pal_idx)),
        .rd_color (rd_color),
        .bg_color (bg_color)
    );

    pcd_mode_sel #(
        .MAX_PLANES   (MAX_PLANES),
        .HIRES_PLANES (HIRES_PLANES),
        .CNT_W        (CNT_W),
        .IDX_W        (IDX_W),
        .COMP_W       (COMP_W)
    ) u_mode (
        .pix_bits   (pix_bits),
        .plane_cnt  (plane_cnt),
        .hires      (hires),
        .ham_req    (ham_en),
        .dual_req   (dual_pf),
        .win_active (win_active),
        .mode       (mode),
        .pal_idx    (pal_idx),
        .ham_ctl    (ham_ctl),
        .ham_val    (ham_val),
        .ehb_bit    (ehb_bit),
        .conflict   (conflict)
    );

    assign ham_upd = pix_valid && (mode == DM_HAM);

    pcd_ham_hold #(
        .COMP_W (COMP_W),
        .RGB_W  (RGB_W)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .upd          (ham_upd),
        .bg_color     (bg_color),
        .direct_color (rd_color),
        .ham_ctl      (ham_ctl),
        .ham_val      (ham_val),
        .ham_color    (ham_color)
    );

    for (genvar k = 0; k < 3; k++) begin : g_half
        assign halved[k*COMP_W +: COMP_W] = {1'b0, rd_color[k*COMP_W+1 +: COMP_W-1]};
    end

    always_comb begin
        unique case (mode)
            DM_BORDER:    next_rgb = bg_color;
            DM_PALETTE:   next_rgb = rd_color;
            DM_HALFBRITE: next_rgb = ehb_bit ? halved : rd_color;
            DM_HAM:       next_rgb = ham_color;
            default:      next_rgb = bg_color;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_out   <= '0;
            rgb_valid <= 1'b0;
            mode_err  <= 1'b0;
        end else begin
            rgb_valid <= pix_valid;
            if (pix_valid) begin
                rgb_out <= next_rgb;
            end
            if (conflict) begin
                mode_err <= 1'b1;
            end
        end
    end

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> rgb_valid);

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !rgb_valid && $stable(rgb_out));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    a_r10_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
        ham_en && dual_pf |=> mode_err);

    a_r9_border: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !win_active |=> rgb_out == $past(bg_color));

    a_r4_half_msbs: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && mode == DM_HALFBRITE && ehb_bit |=>
        !rgb_out[RGB_W-1] && !rgb_out[2*COMP_W-1] && !rgb_out[COMP_W-1]);
endmodule

// File: tb/planar_color_decoder_test.sv
`timescale 1ns/1ps
module planar_color_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;
    logic        line_start;
    logic        pix_valid;
    logic [5:0]  pix_bits;
    logic [2:0]  plane_cnt;
    logic        hires, ham_en, dual_pf, win_active;
    logic [11:0] rgb_out;
    logic        rgb_valid, mode_err;

    int checks = 0;
    int errors = 0;
    logic [11:0] pal_m [32];
    logic [11:0] prev_m;

    always #2 clk = ~clk;

    planar_color_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_start(line_start), .pix_valid(pix_valid),
        .pix_bits(pix_bits), .plane_cnt(plane_cnt), .hires(hires),
        .ham_en(ham_en), .dual_pf(dual_pf), .win_active(win_active),
        .rgb_out(rgb_out), .rgb_valid(rgb_valid), .mode_err(mode_err)
    );

    // {tag, bits, count, hires, ham, dual, window, line_start}
    localparam int NV = 18;
    localparam logic [17:0] VEC [NV] = '{
        {4'd2, 6'b000101, 3'd3, 5'b00010},  // R2 three planes
        {4'd2, 6'b111111, 3'd2, 5'b00010},  // R2 upper bits masked
        {4'd2, 6'b010110, 3'd5, 5'b00010},  // R2 five planes
        {4'd2, 6'b101010, 3'd0, 5'b00010},  // R2 zero planes
        {4'd4, 6'b011111, 3'd7, 5'b00010},  // R4 count 7 acts as 6
        {4'd3, 6'b011111, 3'd5, 5'b10010},  // R3 hires clamp
        {4'd3, 6'b111111, 3'd6, 5'b11010},  // R3 hires blocks hold-and-modify
        {4'd4, 6'b100011, 3'd6, 5'b00010},  // R4 halved
        {4'd4, 6'b000011, 3'd6, 5'b00010},  // R4 full
        {4'd9, 6'b111111, 3'd6, 5'b00000},  // R9 border
        {4'd7, 6'b010101, 3'd6, 5'b01011},  // R7 start of line, blue
        {4'd6, 6'b101010, 3'd6, 5'b01010},  // R6 red
        {4'd6, 6'b111100, 3'd6, 5'b01010},  // R6 green
        {4'd5, 6'b001001, 3'd6, 5'b01010},  // R5 direct
        {4'd8, 6'b010011, 3'd6, 5'b01010},  // R8 hold took direct pick
        {4'd9, 6'b111111, 3'd6, 5'b01000},  // R9 border in hold-and-modify
        {4'd8, 6'b100001, 3'd6, 5'b01010},  // R8 border did not update hold
        {4'd7, 6'b110000, 3'd6, 5'b01011}   // R7 second line start
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
        endcase
    endfunction

    function automatic logic [11:0] palv(input int i);
        return 12'((i * 723 + 345) & 4095);
    endfunction

    task automatic check12(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model(input logic [5:0] b, input logic [2:0] c, input logic h,
                         input logic hm, input logic d, input logic w, input logic ls,
                         output logic [11:0] exp);
        int lim, eff;
        logic [5:0] m;
        logic [11:0] col;
        lim = h ? 4 : 6;
        eff = (int'(c) > lim) ? lim : int'(c);
        for (int i = 0; i < 6; i++) m[i] = b[i] && (i < eff);
        if (ls) prev_m = pal_m[0];
        if (!w) begin
            exp = pal_m[0];
        end else if (eff == 6 && hm && !d) begin
            case (m[5:4])
                2'b00: exp = pal_m[{1'b0, m[3:0]}];
                2'b01: exp = {prev_m[11:4], m[3:0]};
                2'b10: exp = {m[3:0], prev_m[7:0]};
                default: exp = {prev_m[11:8], m[3:0], prev_m[3:0]};
            endcase
            prev_m = exp;
        end else begin
            col = pal_m[m[4:0]];
            if (eff == 6 && !hm && !d && m[5])
                exp = {1'b0, col[11:9], 1'b0, col[7:5], 1'b0, col[3:1]};
            else
                exp = col;
        end
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        pal_m[a] = v[11:0];
    endtask

    task automatic drive_pixel(input logic [5:0] b, input logic [2:0] c, input logic h,
                               input logic hm, input logic d, input logic w, input logic ls);
        pix_bits = b; plane_cnt = c; hires = h; ham_en = hm; dual_pf = d;
        win_active = w; line_start = ls; pix_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        pix_valid = 1'b0; line_start = 1'b0; ham_en = 1'b0; dual_pf = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R11 watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [11:0] exp;
        logic [11:0] held;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        line_start = 1'b0; pix_valid = 1'b0; pix_bits = '0; plane_cnt = '0;
        hires = 1'b0; ham_en = 1'b0; dual_pf = 1'b0; win_active = 1'b0;
        for (int i = 0; i < 32; i++) pal_m[i] = 12'h000;
        prev_m = 12'h000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check12("R12 rgb_out", rgb_out, 12'h000);
        check1("R12 rgb_valid", rgb_valid, 1'b0);
        check1("R12 mode_err", mode_err, 1'b0);
        drive_pixel(6'b000111, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check12("R12 palette cleared", rgb_out, 12'h000);

        // R1 load palette with junk in bits 15:12
        for (int i = 0; i < 32; i++) write_reg(5'(i), {4'hF, palv(i)});

        for (int k = 0; k < NV; k++) begin
            logic [17:0] v;
            v = VEC[k];
            model(v[13:8], v[7:5], v[4], v[3], v[2], v[1], v[0], exp);
            drive_pixel(v[13:8], v[7:5], v[4], v[3], v[2], v[1], v[0]);
            check12(tag_name(v[17:14]), rgb_out, exp);
            check1("R11 valid after pixel", rgb_valid, 1'b1);
        end
        check1("R10 no conflict yet", mode_err, 1'b0);

        // R7 line start with no pixel, then blue modify
        line_start = 1'b1;
        @(posedge clk); @(negedge clk);
        line_start = 1'b0;
        prev_m = pal_m[0];
        check1("R11 no pixel no valid", rgb_valid, 1'b0);
        model(6'b011110, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, exp);
        drive_pixel(6'b011110, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check12("R7 reload alone", rgb_out, exp);

        // R11 idle cycle keeps output
        held = rgb_out;
        @(posedge clk); @(negedge clk);
        check12("R11 idle hold", rgb_out, held);
        check1("R11 idle valid", rgb_valid, 1'b0);

        // R1 register writes
        write_reg(5'd0, 16'hF123);
        drive_pixel(6'b000000, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check12("R1 background write", rgb_out, 12'h123);
        write_reg(5'd17, 16'hABCD);
        drive_pixel(6'b010001, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check12("R1 reg17 write", rgb_out, 12'hBCD);

        // R10 conflicting request
        drive_pixel(6'b110101, 3'd6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check12("R10 plain index", rgb_out, pal_m[21]);
        check1("R10 flag set", mode_err, 1'b1);
        drive_pixel(6'b000010, 3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check12("R10 later pixel", rgb_out, pal_m[2]);
        check1("R10 flag sticky", mode_err, 1'b1);

        // R12 reset clears again
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check1("R12 flag cleared", mode_err, 1'b0);
        check12("R12 output cleared", rgb_out, 12'h000);

        summary();
        $finish;
    end
endmodule